// File: doc/BRIEF.md
# Register Valid-Bit Issue Scoreboard

This block decides, each cycle, whether one instruction from a small window of decoded instructions may be sent to execution. It holds a single ready flag for every architectural register. An instruction is released only when both of its source registers hold settled values and its target register has no result still outstanding. When an instruction is released, the block marks its target register as outstanding. When a functional unit reports a finished result on one of the completion ports, the block marks that register as settled again. A result reported in the current cycle already counts as settled for that cycle's decision.

The window is presented by an upstream queue, with slot 0 as the oldest entry. In strict mode only slot 0 is considered, so a stalled oldest entry holds back everything behind it. In look-past mode the block releases the oldest entry that is both ready and free of ordering conflicts with every valid older entry. The queue removes the released slot itself. The block has no data path and only tracks readiness.

Top module: `regsb_issue`

## Requirements
- R1: After reset, every bit of `reg_valid` is 1.
- R2: A valid slot whose two sources and target all have settled or completing registers can issue. When it issues, `issue_fire` goes to 1 in the same cycle and `issue_slot` holds the slot index.
- R3: From the clock edge that ends an issuing cycle, the `reg_valid` bit of the issued target register reads 0.
- R4: A slot with an outstanding source register that is not completing in that cycle does not issue.
- R5: A slot whose target register is outstanding and not completing in that cycle does not issue, so a write-after-write hazard is never released.
- R6: Each completion port `p` sets bit `wb_reg[p]` of `reg_valid` at the next clock edge. Both ports act in the same cycle, independently of each other.
- R7: A register named on a valid completion port counts as settled in the issue check of that same cycle.
- R8: If the issued target register is also named on a completion port in the same cycle, its `reg_valid` bit reads 0 afterwards. The new issue wins.
- R9: With `ooo_en` = 0, only slot 0 may issue. A blocked or empty slot 0 means no issue, even when younger slots are ready.
- R10: With `ooo_en` = 1, the lowest-index eligible slot issues. Slot 0 is the oldest entry. At most one slot issues per cycle.
- R11: With `ooo_en` = 1, a younger slot does not issue ahead of any valid older slot in three cases: the older slot reads the younger slot's target, the older slot writes the younger slot's target, or the older slot writes one of the younger slot's sources.
- R12: Slots with `slot_vld` = 0 never issue and never block younger slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ooo_en | input | 1 | 1 = look past a blocked oldest slot; 0 = strict order |
| slot_vld | input | WIN | Per-slot occupied flag; bit i is slot i, where slot 0 is the oldest |
| slot_src_a | input | WIN*RW | First source register index per slot; slot i is at bits [i*RW +: RW] |
| slot_src_b | input | WIN*RW | Second source register index per slot; same packing |
| slot_dst | input | WIN*RW | Target register index per slot; same packing |
| wb_vld | input | NUM_WB | Completion port valid flags |
| wb_reg | input | NUM_WB*RW | Completion register index per port; port p is at bits [p*RW +: RW] |
| issue_fire | output | 1 | One slot is released this cycle |
| issue_slot | output | SW | Index of the released slot; meaningful only when issue_fire is 1 |
| reg_valid | output | NUM_REGS | Current per-register settled flags |

## Verification
Two things can land on the same register in the same cycle: an issue that claims a target register, and a completion that releases that register. The bench makes this happen by presenting an instruction whose target is outstanding while a completion port names that same register. It then expects the issue to fire in that cycle through the same-cycle forwarding, and expects the register's flag to stay clear afterwards. A second case lets a completion on a source register release a stalled oldest slot in the cycle of completion. In that case the bench judges both the issue decision and the set-then-clear outcome on the flags at the following edge.

// File: rtl/regsb_pkg.sv
package regsb_pkg;
   typedef enum logic {
      PICK_STRICT   = 1'b0,
      PICK_LOOKPAST = 1'b1
   } pick_mode_e;

   function automatic int unsigned idx_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/regsb_bits.sv
module regsb_bits #(
   parameter int NUM_REGS = 8,
   parameter int NUM_WB   = 2,
   parameter int RW       = 3
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NUM_WB-1:0]      wb_vld,
   input  logic [NUM_WB*RW-1:0]   wb_reg,
   input  logic                   clr_en,
   input  logic [RW-1:0]          clr_reg,
   output logic [NUM_REGS-1:0]    valid_q,
   output logic [NUM_REGS-1:0]    avail
);
   logic [NUM_REGS-1:0] set_vec;
   logic [NUM_REGS-1:0] clr_vec;

   always_comb begin
      set_vec = '0;
      for (int p = 0; p < NUM_WB; p++) begin
         if (wb_vld[p]) set_vec[wb_reg[p*RW +: RW]] = 1'b1;
      end
   end

   always_comb begin
      clr_vec = '0;
      if (clr_en) clr_vec[clr_reg] = 1'b1;
   end

   // completions first, then the issuing claim overrides
   always_ff @(posedge clk) begin
      if (!rst_n) valid_q <= '1;
      else        valid_q <= (valid_q | set_vec) & ~clr_vec;
   end

   assign avail = valid_q | set_vec;
endmodule

// File: rtl/regsb_hazard.sv
module regsb_hazard #(
   parameter int NUM_REGS = 8,
   parameter int WIN      = 4,
   parameter int RW       = 3
) (
   input  logic                 lookpast,
   input  logic [NUM_REGS-1:0]  avail,
   input  logic [WIN-1:0]       slot_vld,
   input  logic [WIN*RW-1:0]    slot_src_a,
   input  logic [WIN*RW-1:0]    slot_src_b,
   input  logic [WIN*RW-1:0]    slot_dst,
   output logic [WIN-1:0]       ready
);
   for (genvar g = 0; g < WIN; g++) begin : g_slot
      logic [RW-1:0] sa, sb, sd;
      logic          ops_ok;
      assign sa = slot_src_a[g*RW +: RW];
      assign sb = slot_src_b[g*RW +: RW];
      assign sd = slot_dst[g*RW +: RW];
      assign ops_ok = slot_vld[g] & avail[sa] & avail[sb] & avail[sd];

      if (g == 0) begin : g_head
         assign ready[g] = ops_ok;
      end else begin : g_young
         logic order_blk;
         always_comb begin
            order_blk = 1'b0;
            for (int k = 0; k < g; k++) begin
               if (slot_vld[k]) begin
                  if (slot_dst[k*RW +: RW]   == sd) order_blk = 1'b1;
                  if (slot_src_a[k*RW +: RW] == sd) order_blk = 1'b1;
                  if (slot_src_b[k*RW +: RW] == sd) order_blk = 1'b1;
                  if (slot_dst[k*RW +: RW]   == sa) order_blk = 1'b1;
                  if (slot_dst[k*RW +: RW]   == sb) order_blk = 1'b1;
               end
            end
         end
         assign ready[g] = ops_ok & lookpast & ~order_blk;
      end
   end
endmodule

// File: rtl/regsb_pick.sv
module regsb_pick #(
   parameter int WIN = 4,
   parameter int SW  = 2
) (
   input  logic [WIN-1:0] ready,
   output logic           fire,
   output logic [SW-1:0]  slot,
   output logic [WIN-1:0] grant
);
   always_comb begin
      slot  = '0;
      grant = '0;
      for (int i = WIN-1; i >= 0; i--) begin
         if (ready[i]) begin
            slot  = SW'(i);
            grant = '0;
            grant[i] = 1'b1;
         end
      end
   end
   assign fire = |ready;
endmodule

// File: rtl/regsb_issue.sv
module regsb_issue #(
   parameter int NUM_REGS = 8,
   parameter int NUM_WB   = 2,
   parameter int WIN      = 4,
   parameter int RW       = regsb_pkg::idx_width(NUM_REGS),
   parameter int SW       = regsb_pkg::idx_width(WIN)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  ooo_en,
   input  logic [WIN-1:0]        slot_vld,
   input  logic [WIN*RW-1:0]     slot_src_a,
   input  logic [WIN*RW-1:0]     slot_src_b,
   input  logic [WIN*RW-1:0]     slot_dst,
   input  logic [NUM_WB-1:0]     wb_vld,
   input  logic [NUM_WB*RW-1:0]  wb_reg,
   output logic                  issue_fire,
   output logic [SW-1:0]         issue_slot,
   output logic [NUM_REGS-1:0]   reg_valid
);
   import regsb_pkg::*;

   localparam int REG_SPAN = 1 << RW;

   if (NUM_REGS < 2 || REG_SPAN != NUM_REGS) begin : g_chk_regs
      $error("regsb_issue: NUM_REGS must be a power of two >= 2");
   end
   if (WIN < 1 || WIN > 16) begin : g_chk_win
      $error("regsb_issue: WIN must lie in 1..16");
   end
   if (NUM_WB < 1) begin : g_chk_wb
      $error("regsb_issue: NUM_WB must be at least 1");
   end

   pick_mode_e        mode;
   logic [NUM_REGS-1:0] avail;
   logic [WIN-1:0]    ready;
   logic [WIN-1:0]    grant;
   logic [RW-1:0]     iss_dst;

   assign mode = ooo_en ? PICK_LOOKPAST : PICK_STRICT;

   regsb_bits #(.NUM_REGS(NUM_REGS), .NUM_WB(NUM_WB), .RW(RW)) u_bits (
      .clk     (clk),
      .rst_n   (rst_n),
      .wb_vld  (wb_vld),
      .wb_reg  (wb_reg),
      .clr_en  (issue_fire),
      .clr_reg (iss_dst),
      .valid_q (reg_valid),
      .avail   (avail)
   );

   regsb_hazard #(.NUM_REGS(NUM_REGS), .WIN(WIN), .RW(RW)) u_haz (
      .lookpast   (mode == PICK_LOOKPAST),
      .avail      (avail),
      .slot_vld   (slot_vld),
      .slot_src_a (slot_src_a),
      .slot_src_b (slot_src_b),
      .slot_dst   (slot_dst),
      .ready      (ready)
   );

   regsb_pick #(.WIN(WIN), .SW(SW)) u_pick (
      .ready (ready),
      .fire  (issue_fire),
      .slot  (issue_slot),
      .grant (grant)
   );

   always_comb begin
      iss_dst = '0;
      for (int i = 0; i < WIN; i++) begin
         if (grant[i]) iss_dst = iss_dst | slot_dst[i*RW +: RW];
      end
   end
endmodule

// File: rtl/regsb_issue_chk.sv
module regsb_issue_chk #(
   parameter int NUM_REGS = 8,
   parameter int NUM_WB   = 2,
   parameter int WIN      = 4,
   parameter int RW       = 3,
   parameter int SW       = 2
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  ooo_en,
   input logic [WIN-1:0]        slot_vld,
   input logic [WIN*RW-1:0]     slot_src_a,
   input logic [WIN*RW-1:0]     slot_src_b,
   input logic [WIN*RW-1:0]     slot_dst,
   input logic [NUM_WB-1:0]     wb_vld,
   input logic [NUM_WB*RW-1:0]  wb_reg,
   input logic                  issue_fire,
   input logic [SW-1:0]         issue_slot,
   input logic [NUM_REGS-1:0]   reg_valid
);
   logic [RW-1:0]       c_dst, c_sa, c_sb;
   logic [NUM_REGS-1:0] c_wbhit;
   logic                c_live;

   always_comb begin
      c_dst = '0; c_sa = '0; c_sb = '0; c_live = 1'b0;
      for (int i = 0; i < WIN; i++) begin
         if (issue_slot == SW'(i)) begin
            c_dst  = slot_dst[i*RW +: RW];
            c_sa   = slot_src_a[i*RW +: RW];
            c_sb   = slot_src_b[i*RW +: RW];
            c_live = slot_vld[i];
         end
      end
      c_wbhit = '0;
      for (int p = 0; p < NUM_WB; p++)
         if (wb_vld[p]) c_wbhit[wb_reg[p*RW +: RW]] = 1'b1;
   end

   assert_slot_live_R12: assert property (@(posedge clk) disable iff (!rst_n)
      issue_fire |-> c_live);

   assert_strict_head_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_fire && !ooo_en) |-> (issue_slot == '0));

   assert_srcs_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
      issue_fire |-> ((reg_valid[c_sa] || c_wbhit[c_sa]) && (reg_valid[c_sb] || c_wbhit[c_sb])));

   assert_dst_free_R5: assert property (@(posedge clk) disable iff (!rst_n)
      issue_fire |-> (reg_valid[c_dst] || c_wbhit[c_dst]));

   assert_dst_claimed_R3: assert property (@(posedge clk) disable iff (!rst_n)
      issue_fire |=> !reg_valid[$past(c_dst)]);

   for (genvar p = 0; p < NUM_WB; p++) begin : g_wb
      assert_wb_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (wb_vld[p] && !(issue_fire && c_dst == wb_reg[p*RW +: RW]))
            |=> reg_valid[$past(wb_reg[p*RW +: RW])]);
   end
endmodule

bind regsb_issue regsb_issue_chk #(
   .NUM_REGS(NUM_REGS), .NUM_WB(NUM_WB), .WIN(WIN), .RW(RW), .SW(SW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .ooo_en(ooo_en), .slot_vld(slot_vld),
   .slot_src_a(slot_src_a), .slot_src_b(slot_src_b), .slot_dst(slot_dst),
   .wb_vld(wb_vld), .wb_reg(wb_reg), .issue_fire(issue_fire),
   .issue_slot(issue_slot), .reg_valid(reg_valid)
);

// File: tb/regsb_issue_tb.sv
module regsb_issue_tb;
   localparam int CLK_PERIOD = 10;

   typedef struct packed {
      logic        ooo;
      logic [3:0]  vld;
      logic [11:0] sa;
      logic [11:0] sb;
      logic [11:0] d;
      logic [1:0]  wbv;
      logic [5:0]  wbr;
      logic        fire;
      logic [1:0]  slot;
      logic [7:0]  rv;
   } vec_t;

   // slot fields in octal: digit order slot3..slot0; wbr digits port1,port0
   localparam int NV = 10;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 4'b0001, 12'o0001, 12'o0002, 12'o0003, 2'b00, 6'o00, 1'b1, 2'd0, 8'hF7}, // R2 R3
      '{1'b0, 4'b0011, 12'o0013, 12'o0022, 12'o0054, 2'b00, 6'o00, 1'b0, 2'd0, 8'hF7}, // R4 R9
      '{1'b1, 4'b0011, 12'o0013, 12'o0022, 12'o0054, 2'b00, 6'o00, 1'b1, 2'd1, 8'hD7}, // R10
      '{1'b1, 4'b1111, 12'o4003, 12'o0002, 12'o6244, 2'b00, 6'o00, 1'b0, 2'd0, 8'hD7}, // R11
      '{1'b0, 4'b0001, 12'o0003, 12'o0002, 12'o0004, 2'b10, 6'o30, 1'b1, 2'd0, 8'hCF}, // R7
      '{1'b0, 4'b0001, 12'o0000, 12'o0001, 12'o0005, 2'b00, 6'o00, 1'b0, 2'd0, 8'hCF}, // R5
      '{1'b0, 4'b0001, 12'o0000, 12'o0001, 12'o0005, 2'b01, 6'o05, 1'b1, 2'd0, 8'hCF}, // R8
      '{1'b1, 4'b0000, 12'o0000, 12'o0001, 12'o0005, 2'b11, 6'o54, 1'b0, 2'd0, 8'hFF}, // R6 R12
      '{1'b1, 4'b0110, 12'o0000, 12'o0110, 12'o0620, 2'b00, 6'o00, 1'b1, 2'd1, 8'hFB}, // R10 R12
      '{1'b0, 4'b0010, 12'o0000, 12'o0110, 12'o0620, 2'b00, 6'o00, 1'b0, 2'd0, 8'hFB}  // R9
   };
   localparam string TAGS [NV] = '{"R2/R3", "R4/R9", "R10", "R11", "R7",
                                   "R5", "R8", "R6/R12", "R10/R12", "R9"};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ooo_en = 1'b0;
   logic [3:0]  slot_vld = '0;
   logic [11:0] slot_src_a = '0, slot_src_b = '0, slot_dst = '0;
   logic [1:0]  wb_vld = '0;
   logic [5:0]  wb_reg = '0;
   logic        issue_fire;
   logic [1:0]  issue_slot;
   logic [7:0]  reg_valid;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   regsb_issue u_dut (
      .clk(clk), .rst_n(rst_n), .ooo_en(ooo_en), .slot_vld(slot_vld),
      .slot_src_a(slot_src_a), .slot_src_b(slot_src_b), .slot_dst(slot_dst),
      .wb_vld(wb_vld), .wb_reg(wb_reg), .issue_fire(issue_fire),
      .issue_slot(issue_slot), .reg_valid(reg_valid)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 reset flags", 32'(reg_valid), 32'hFF);
      check("R12 idle no issue", 32'(issue_fire), 32'd0);

      for (int i = 0; i < NV; i++) begin
         ooo_en     = VECS[i].ooo;
         slot_vld   = VECS[i].vld;
         slot_src_a = VECS[i].sa;
         slot_src_b = VECS[i].sb;
         slot_dst   = VECS[i].d;
         wb_vld     = VECS[i].wbv;
         wb_reg     = VECS[i].wbr;
         #1;
         check({TAGS[i], " fire"}, 32'(issue_fire), 32'(VECS[i].fire));
         if (VECS[i].fire)
            check({TAGS[i], " slot"}, 32'(issue_slot), 32'(VECS[i].slot));
         @(negedge clk);
         check({TAGS[i], " flags"}, 32'(reg_valid), 32'(VECS[i].rv));
      end

      // R1: reset mid-run restores every flag
      slot_vld = '0;
      wb_vld   = '0;
      rst_n    = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      check("R1 re-reset flags", 32'(reg_valid), 32'hFF);

      // R9: strict mode, empty head, ready younger slot stays put
      ooo_en = 1'b0; slot_vld = 4'b1000;
      slot_src_a = 12'o1000; slot_src_b = 12'o1000; slot_dst = 12'o7000;
      #1;
      check("R9 empty head", 32'(issue_fire), 32'd0);
      @(negedge clk);
      check("R9 flags untouched", 32'(reg_valid), 32'hFF);

      slot_vld = '0;
      @(negedge clk);
      finish_run();
   end
endmodule